// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash bus. After software or another engine has issued a program or erase command, a single `start` pulse hands the wait to this controller. The controller issues status reads in pairs over a request/response read channel. It compares the toggle bit between the two reads of a pair and watches the error flag. It ends with a held verdict: `done` plus exactly one of `pass` or `fail`.

A toggling pair with the error flag low starts another pair. A toggling pair with the error flag high starts one confirming pair, because the toggling may have stopped at the same moment the flag rose. Toggling in that confirming pair means failure. Every failure sends a single reset command byte over a write channel, and `done` rises only after the bus accepts that write. A programmable limit on low-flag toggling pairs turns a stuck device into a failure.

The read request, read response and write channels follow valid/ready rules. A valid output stays asserted, with its payload unchanged, until the cycle in which the matching ready is high. The transfer completes on that clock edge. The bus may hold ready low for any number of cycles. On the read response channel the controller drives ready and accepts one byte for each request it has issued.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `fail`, `rd_req_valid` and `wr_valid` are all low.
- R2: A `start` pulse while idle clears `done`, `pass` and `fail`, raises `busy` and opens a read pair. A `start` while busy has no effect on the read sequence or on the verdict.
- R3: `rd_req_valid` stays high until accepted by `rd_req_ready`. A response byte is taken only in a cycle where both `rd_data_valid` and `rd_data_ready` are high. Only bit 6 (toggle) and bit 5 (error flag) of a status byte influence the controller.
- R4: If bit 6 matches across the two reads of a pair, the controller sets `done` and `pass`, issues no write, and makes no further reads.
- R5: If bit 6 differs and bit 5 of the second read is low, another pair of reads follows, unless the pair limit of R8 is reached.
- R6: If bit 6 differs and bit 5 of the second read is high, one confirming pair always follows, even when the limit of R8 is reached. A match in that pair gives `pass`.
- R7: If bit 6 differs in the confirming pair, `fail` is set and exactly one write of 0xF0 is issued. `done` rises only after that write is accepted.
- R8: The pair with index k (counting from 1), if it toggles with bit 5 low, ends in failure with the reset write of R7 when k >= `max_pairs`. A `max_pairs` of 0 behaves as 1.
- R9: `pass` and `fail` are never both high. `done`, `pass` and `fail` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin polling (taken only while idle) |
| max_pairs | input | CNT_W | Limit on low-flag toggling read pairs |
| busy | output | 1 | Polling in progress |
| done | output | 1 | Verdict available (held) |
| pass | output | 1 | Operation completed (held) |
| fail | output | 1 | Operation failed or timed out (held) |
| rd_req_valid | output | 1 | Status read request |
| rd_req_ready | input | 1 | Bus accepts read request |
| rd_data_valid | input | 1 | Status byte available |
| rd_data_ready | output | 1 | Controller accepts status byte |
| rd_data | input | DATA_W | Status byte |
| wr_valid | output | 1 | Reset command write request |
| wr_ready | input | 1 | Bus accepts write |
| wr_data | output | DATA_W | Reset command byte (0xF0) |

## Verification
The bench sweeps the number of low-flag toggling pairs, three endings (toggling stops, the flag rises and then toggling stops, the flag rises and toggling goes on) and several pair limits, with stalls on every channel. The sharpest case is a first pair that toggles with the flag high. A design that trusts that pair fails an operation that actually finished, and the bench sees too few reads and an unwanted reset write. A limit at or below the number of low-flag pairs must produce exactly 2*max(limit,1) reads. An off-by-one counter shows up as one pair too many or too few. A `start` injected mid-run would add reads if it were not ignored, and a `done` raised before the write handshake would appear with no write counted.

// File: rtl/toggle_poll_pkg.sv
package toggle_poll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_RST
  } poll_state_e;
endpackage

// File: rtl/tp_toggle_cmp.sv
module tp_toggle_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic bit_in,
  output logic differs
);
  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= 1'b0;
    else if (capture) held_q <= bit_in;
  end

  assign differs = bit_in ^ held_q;
endmodule

// File: rtl/tp_pair_counter.sv
module tp_pair_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  input  logic [CNT_W-1:0] limit,
  output logic             at_limit
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q;
  logic [CNT_W:0]   count_inc;

  assign count_inc = {1'b0, count_q} + 1'b1;
  // true when the pair now being counted reaches the limit
  assign at_limit  = count_inc >= {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count_q <= '0;
    else if (clear)                    count_q <= '0;
    else if (bump && count_q != CNT_MAX) count_q <= count_inc[CNT_W-1:0];
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count_q == '0); // R8
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int               DATA_W     = 8,
  parameter int               TOGGLE_IDX = 6,
  parameter int               ERR_IDX    = 5,
  parameter int               CNT_W      = 8,
  parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  max_pairs,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rd_data_valid,
  output logic              rd_data_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data
);
  import toggle_poll_pkg::*;

  poll_state_e state_q;
  logic first_q, confirm_q;
  logic done_q, pass_q, fail_q;
  logic take, differs, at_limit, err_bit;
  logic cnt_bump, cnt_clear, cap_first;
  logic unused_bits;

  assign unused_bits = ^rd_data;
  assign err_bit     = rd_data[ERR_IDX];
  assign take        = (state_q == ST_WAIT) && rd_data_valid;
  assign cap_first   = take && first_q;
  assign cnt_clear   = (state_q == ST_IDLE) && start;
  assign cnt_bump    = take && !first_q && differs && !confirm_q && !err_bit;

  tp_toggle_cmp u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (cap_first),
    .bit_in  (rd_data[TOGGLE_IDX]),
    .differs (differs)
  );

  tp_pair_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .bump     (cnt_bump),
    .limit    (max_pairs),
    .at_limit (at_limit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      first_q   <= 1'b1;
      confirm_q <= 1'b0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          done_q    <= 1'b0;
          pass_q    <= 1'b0;
          fail_q    <= 1'b0;
          first_q   <= 1'b1;
          confirm_q <= 1'b0;
          state_q   <= ST_REQ;
        end
        ST_REQ: if (rd_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (rd_data_valid) begin
          if (first_q) begin
            first_q <= 1'b0;
            state_q <= ST_REQ;
          end else if (!differs) begin
            pass_q  <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (confirm_q) begin
            fail_q  <= 1'b1;
            state_q <= ST_RST;
          end else if (err_bit) begin
            confirm_q <= 1'b1;
            first_q   <= 1'b1;
            state_q   <= ST_REQ;
          end else if (at_limit) begin
            fail_q  <= 1'b1;
            state_q <= ST_RST;
          end else begin
            first_q <= 1'b1;
            state_q <= ST_REQ;
          end
        end
        ST_RST: if (wr_ready) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = state_q != ST_IDLE;
  assign done          = done_q;
  assign pass          = pass_q;
  assign fail          = fail_q;
  assign rd_req_valid  = state_q == ST_REQ;
  assign rd_data_ready = state_q == ST_WAIT;
  assign wr_valid      = state_q == ST_RST;
  assign wr_data       = RESET_CMD;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !wr_valid); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data)); // R7
  AST_WR_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> fail && !done); // R7
  AST_PF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail)); // R9
  AST_DONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail)); // R9
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(pass) && $stable(fail)); // R9
endmodule

// File: tb/toggle_poll_ctrl_tb.sv
`timescale 1ns/1ps
module toggle_poll_ctrl_tb;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] max_pairs = '0;
  logic busy, done, pass, fail;
  logic rd_req_valid, rd_data_ready, wr_valid;
  logic rd_req_ready = 1'b0;
  logic rd_data_valid = 1'b0;
  logic wr_ready = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic [7:0] wr_data;

  always #4 clk = ~clk;

  toggle_poll_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .max_pairs(max_pairs),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_data_valid(rd_data_valid), .rd_data_ready(rd_data_ready),
    .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int rd_cnt = 0, wr_cnt = 0, wr_bad = 0;
  int cfg_nlow = 0, cfg_mode = 0, cfg_lat = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status_byte(input int r);
    int p;
    bit tog, d5;
    logic [7:0] b;
    p = r / 2;
    if (p < cfg_nlow)       begin tog = 1; d5 = 0; end
    else if (cfg_mode == 0) begin tog = 0; d5 = 0; end
    else if (cfg_mode == 1) begin tog = (p == cfg_nlow); d5 = 1; end
    else                    begin tog = 1; d5 = 1; end
    b = (8'(r) * 8'h5B) ^ 8'hA6;  // noise in the bits that must be ignored (R3)
    b[6] = tog ? r[0] : 1'b1;
    b[5] = d5;
    return b;
  endfunction

  // bus responder: accounts handshakes of the previous edge, then drives
  initial begin
    bit p_rqv = 0, p_rqr = 0, p_dv = 0, p_dr = 0, p_wv = 0, p_wr = 0;
    bit pending = 0;
    int delay = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
      if (p_rqv && p_rqr) begin pending = 1; delay = cfg_lat; end
      if (p_dv && p_dr) begin rd_cnt++; rd_data_valid = 1'b0; end
      if (p_wv && p_wr) begin wr_cnt++; if (wr_data != 8'hF0) wr_bad++; end
      rd_req_ready = (cyc % 3) != 1;
      wr_ready     = (cyc % 4) == 0;
      if (pending && !rd_data_valid) begin
        if (delay == 0) begin
          rd_data_valid = 1'b1;
          rd_data = status_byte(rd_cnt);
          pending = 0;
        end else delay--;
      end
      p_rqv = rd_req_valid; p_rqr = rd_req_ready;
      p_dv = rd_data_valid; p_dr = rd_data_ready;
      p_wv = wr_valid; p_wr = wr_ready;
    end
  end

  task automatic run(input int nlow, input int mode, input int m, input int lat);
    int meff, exp_reads, t;
    bit exp_fail;
    cfg_nlow = nlow; cfg_mode = mode; cfg_lat = lat;
    max_pairs = CNT_W'(m);
    meff = (m == 0) ? 1 : m;
    if (nlow > 0 && meff <= nlow) begin exp_fail = 1; exp_reads = 2 * meff; end // R8
    else if (mode == 0) begin exp_fail = 0; exp_reads = 2 * (nlow + 1); end      // R4 R5
    else if (mode == 1) begin exp_fail = 0; exp_reads = 2 * (nlow + 2); end      // R6
    else begin exp_fail = 1; exp_reads = 2 * (nlow + 2); end                     // R7
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; wr_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !pass && !fail, "R2 start clears verdict", {busy, done, pass, fail}, 4'b1000);
    @(negedge clk);
    @(negedge clk);
    start = 1'b1;  // must be ignored while busy (R2)
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 600) begin @(negedge clk); t++; end
    chk(done && !busy, "R2 run completes", done, 1);
    repeat (3) @(negedge clk);
    chk(rd_cnt == exp_reads, "R5 R6 R8 read count", rd_cnt, exp_reads);
    chk(pass == !exp_fail && fail == exp_fail, "R4 R6 R7 verdict", fail, exp_fail);
    chk(wr_cnt == (exp_fail ? 1 : 0) && wr_bad == 0, "R7 reset write", wr_cnt, exp_fail ? 1 : 0);
    chk(done && (pass ^ fail), "R9 verdict held", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !fail && !rd_req_valid && !wr_valid,
        "R1 reset state", {busy, done, pass, fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_req_valid, "R1 idle after reset", busy, 0);
    for (int nlow = 0; nlow < 4; nlow++)
      for (int mode = 0; mode < 3; mode++)
        for (int mi = 0; mi < 5; mi++)
          run(nlow, mode, (mi == 4) ? 5 : mi, (nlow + mode + mi) % 3);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule